// File: doc/BRIEF.md
# Packed SIMD Lane Adder/Subtractor

This block adds or subtracts two packed integer vectors lane by lane and registers the result. The lane width is 8, 16, 32 or 64 bits. Four operand/result shapes are handled by one datapath. The **same-width** shape keeps lane width and type. The **widening** shape extends two 64-bit vectors into a 128-bit result with double-width lanes. The **mixed** shape combines a double-width 128-bit first operand with a single-width 64-bit second operand. The **halving** shape takes two double-width 128-bit operands and returns the upper half of each lane sum or difference as a 64-bit vector.

Each operation can wrap or saturate, with the clamp range chosen by a signed flag. Any clamped lane sets a sticky flag. Only an explicit clear input resets that flag. A pipeline or datapath controller issues one operation per cycle with `valid_i` and collects the result one cycle later.

Top module: `simd_lane_alu`

## Requirements
- R1: With `shape_i`=0 (same-width), `size_i` picks the lane width (0=8, 1=16, 2=32, 3=64 bits). `op_i` picks the operation (0=add, 1=subtract). Each lane of `res_o` is the modulo-2^W result of the lane pair. When `quad_i`=1 all 128 bits are processed. When `quad_i`=0 only bits 63:0 are processed and `res_o[127:64]` is zero.
- R2: With `shape_i`=1 (widening), the lanes of width E=8<<`size_i` in `a_i[63:0]` and `b_i[63:0]` are sign-extended (`signed_i`=1) or zero-extended to 2E bits. They are then combined into 2E-bit lanes that fill all 128 bits of `res_o`.
- R3: With `shape_i`=2 (mixed), `a_i` holds 2E-bit lanes. Each is combined with the matching E-bit lane of `b_i[63:0]`, which is extended per `signed_i`. The result is a 2E-bit lane.
- R4: With `shape_i`=3 (halving), `a_i` and `b_i` hold 2E-bit lanes. Result lane i in `res_o[63:0]` is the upper E bits of the 2E-bit lane result, and `res_o[127:64]` is zero.
- R5: With `sat_i`=1 and `signed_i`=1, a lane result above the two's-complement maximum of its result width becomes that maximum, and one below the minimum becomes that minimum. For the halving shape the clamp is applied to the 2E-bit result before its upper half is taken.
- R6: With `sat_i`=1 and `signed_i`=0, an add that overflows gives all-ones and a subtract that borrows gives zero.
- R7: `sat_o` rises one cycle after an accepted operation clamps any lane. It then stays high until a cycle with `sat_clr_i`=1. If a clamp and a clear occur in the same cycle, the flag ends up set.
- R8: `res_o` and `valid_o` reflect the operation accepted on the previous clock edge. `valid_o` equals the previous `valid_i`, and `res_o` holds its value when `valid_i` was low.
- R9: With `size_i`=3 and a shape other than same-width, the result is all zero and no clamp is reported.
- R10: After reset, `valid_o`, `res_o` and `sat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 1 | 0 add, 1 subtract |
| shape_i | input | 2 | 0 same-width, 1 widening, 2 mixed, 3 halving |
| size_i | input | 2 | Narrow lane width code: 0=8, 1=16, 2=32, 3=64 |
| quad_i | input | 1 | Same-width shape: 1 = 128-bit, 0 = 64-bit vector |
| signed_i | input | 1 | Signed lanes and clamp range |
| sat_i | input | 1 | Saturating mode |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Result vector |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A wrong lane-engine selection or a wrong extension shows up in `res_o` on the very next cycle for the affected lanes. Because of this, the bench compares every accepted operation against a lane model built on plain arithmetic comparisons. A corrupted sticky flag cannot hide. It is compared on every cycle, including idle and clear-only cycles, so a missed set or an early drop shows within one cycle. Extreme patterns (0x7f, 0x80 and all-ones lanes) are mixed into the random stream so that the clamp paths of every width and shape are hit.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    SHP_SAME   = 2'd0,
    SHP_WIDEN  = 2'd1,
    SHP_MIXED  = 2'd2,
    SHP_HALVE  = 2'd3
  } shape_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  localparam int MIN_LANE_W = 8;
endpackage

// File: rtl/simd_lane_engine.sv
module simd_lane_engine #(
  parameter int LW = 8,
  parameter int VW = 128
) (
  input  logic [VW-1:0] x_i,
  input  logic [VW-1:0] y_i,
  input  logic          sub_i,
  input  logic          sgn_i,
  input  logic          sat_i,
  output logic [VW-1:0] r_o,
  output logic          ovf_o
);
  localparam int NL = VW / LW;

  logic [NL-1:0] ovf;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW:0]   xe, ye, ex;
    logic          of;
    logic [LW-1:0] clamp;
    always_comb begin
      xe = {sgn_i & x_i[g*LW+LW-1], x_i[g*LW +: LW]};
      ye = {sgn_i & y_i[g*LW+LW-1], y_i[g*LW +: LW]};
      ex = sub_i ? (xe - ye) : (xe + ye);
      if (sgn_i) begin
        // true sign is the extra bit; overflow when it disagrees with lane msb
        of    = ex[LW] ^ ex[LW-1];
        clamp = ex[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
      end else begin
        of    = ex[LW];
        clamp = sub_i ? '0 : '1;
      end
      ovf[g] = sat_i & of;
      r_o[g*LW +: LW] = ovf[g] ? clamp : ex[LW-1:0];
    end
  end

  assign ovf_o = |ovf;
endmodule

// File: rtl/simd_widen.sv
module simd_widen #(
  parameter int EW = 8,
  parameter int HW = 64
) (
  input  logic [HW-1:0]   d_i,
  input  logic            sgn_i,
  output logic [2*HW-1:0] q_o
);
  localparam int NL = HW / EW;

  for (genvar g = 0; g < NL; g++) begin : g_ext
    assign q_o[g*2*EW +: 2*EW] = {{EW{sgn_i & d_i[g*EW+EW-1]}}, d_i[g*EW +: EW]};
  end
endmodule

// File: rtl/simd_halve.sv
module simd_halve #(
  parameter int EW = 8,
  parameter int HW = 64
) (
  input  logic [2*HW-1:0] w_i,
  output logic [HW-1:0]   n_o
);
  localparam int NL = HW / EW;

  for (genvar g = 0; g < NL; g++) begin : g_pack
    assign n_o[g*EW +: EW] = w_i[g*2*EW+EW +: EW];
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          op_i,
  input  logic [1:0]    shape_i,
  input  logic [1:0]    size_i,
  input  logic          quad_i,
  input  logic          signed_i,
  input  logic          sat_i,
  input  logic          sat_clr_i,
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  output logic          valid_o,
  output logic [VW-1:0] res_o,
  output logic          sat_o
);
  localparam int HW  = VW / 2;
  localparam int NSZ = $clog2(HW) - $clog2(MIN_LANE_W) + 1;

  shape_e shape;
  assign shape = shape_e'(shape_i);

  logic [VW-1:0] a_m, b_m;
  logic [VW-1:0] eng_x [NSZ];
  logic [VW-1:0] eng_y [NSZ];
  logic [VW-1:0] eng_r [NSZ];
  logic [NSZ-1:0] eng_ovf;
  logic [VW-1:0] wa [NSZ];
  logic [VW-1:0] wb [NSZ];
  logic [HW-1:0] hr [NSZ];

  // 64-bit same-width mode: zero upper half so those lanes never clamp
  assign a_m = quad_i ? a_i : {{HW{1'b0}}, a_i[HW-1:0]};
  assign b_m = quad_i ? b_i : {{HW{1'b0}}, b_i[HW-1:0]};

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int LW = MIN_LANE_W << k;

    if (k == NSZ - 1) begin : g_top
      assign wa[k] = '0;
      assign wb[k] = '0;
      assign hr[k] = '0;
    end else begin : g_ext
      simd_widen #(.EW(LW), .HW(HW)) u_wa (.d_i(a_i[HW-1:0]), .sgn_i(signed_i), .q_o(wa[k]));
      simd_widen #(.EW(LW), .HW(HW)) u_wb (.d_i(b_i[HW-1:0]), .sgn_i(signed_i), .q_o(wb[k]));
      simd_halve #(.EW(LW), .HW(HW)) u_hv (.w_i(eng_r[k+1]), .n_o(hr[k]));
    end

    if (k == 0) begin : g_in0
      assign eng_x[k] = a_m;
      assign eng_y[k] = b_m;
    end else begin : g_inn
      always_comb begin
        unique case (shape)
          SHP_SAME:  begin eng_x[k] = a_m;      eng_y[k] = b_m;      end
          SHP_WIDEN: begin eng_x[k] = wa[k-1];  eng_y[k] = wb[k-1];  end
          SHP_MIXED: begin eng_x[k] = a_i;      eng_y[k] = wb[k-1];  end
          default:   begin eng_x[k] = a_i;      eng_y[k] = b_i;      end
        endcase
      end
    end

    simd_lane_engine #(.LW(LW), .VW(VW)) u_eng (
      .x_i  (eng_x[k]),
      .y_i  (eng_y[k]),
      .sub_i(op_i == OP_SUB),
      .sgn_i(signed_i),
      .sat_i(sat_i),
      .r_o  (eng_r[k]),
      .ovf_o(eng_ovf[k])
    );
  end

  logic [VW-1:0] res_d;
  logic          ovf_d;
  logic [1:0]    sel_dbl;

  assign sel_dbl = size_i + 2'd1;

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    if (shape == SHP_SAME) begin
      res_d = eng_r[size_i];
      if (!quad_i) res_d[VW-1:HW] = '0;
      ovf_d = eng_ovf[size_i];
    end else if (int'(size_i) < NSZ - 1) begin
      ovf_d = eng_ovf[sel_dbl];
      if (shape == SHP_HALVE) res_d = {{HW{1'b0}}, hr[size_i]};
      else                    res_d = eng_r[sel_dbl];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
      sat_o <= (sat_o & ~sat_clr_i) | (valid_i & ovf_d);
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int VW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [1:0]    shape_i,
  input logic [1:0]    size_i,
  input logic          sat_i,
  input logic          sat_clr_i,
  input logic          valid_o,
  input logic [VW-1:0] res_o,
  input logic          sat_o
);
  localparam int HW = VW / 2;

  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_res_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  assert_sat_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !sat_clr_i |=> sat_o);
  assert_sat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_clr_i && !(valid_i && sat_i) |=> !sat_o);
  assert_no_clamp_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_o && !(valid_i && sat_i) |=> !sat_o);
  assert_halve_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && shape_i == 2'd3 |=> res_o[VW-1:HW] == '0);
  assert_big_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && shape_i != 2'd0 && size_i == 2'd3 |=> res_o == '0);
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.VW(VW)) u_chk (.*);

// File: tb/tb_simd_lane_alu.sv
`timescale 1ns/1ps
module tb_simd_lane_alu;
  localparam int VW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, op_i = 1'b0, quad_i = 1'b0;
  logic          signed_i = 1'b0, sat_i = 1'b0, sat_clr_i = 1'b0;
  logic [1:0]    shape_i = '0, size_i = '0;
  logic [VW-1:0] a_i = '0, b_i = '0;
  logic          valid_o, sat_o;
  logic [VW-1:0] res_o;

  int  checks = 0;
  int  fails  = 0;
  bit  exp_sat = 1'b0;
  logic [VW-1:0] last_res = '0;

  always #4 clk_i = ~clk_i;

  simd_lane_alu #(.VW(VW)) dut (.*);

  function automatic logic [63:0] msk(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] lane_calc(logic [63:0] x, int xw, logic [63:0] y, int yw,
                                            int w, bit sgn, bit sat, bit sub, output bit ov);
    logic signed [67:0] xv, yv, r, mx, mn, one;
    one = 68'sd1;
    xv = {4'b0, x & msk(xw)};
    yv = {4'b0, y & msk(yw)};
    if (sgn && x[xw-1]) xv = xv - (one <<< xw);
    if (sgn && y[yw-1]) yv = yv - (one <<< yw);
    r = sub ? xv - yv : xv + yv;
    if (sgn) begin mx = (one <<< (w-1)) - one; mn = -(one <<< (w-1)); end
    else     begin mx = (one <<< w) - one;     mn = 68'sd0; end
    ov = 1'b0;
    if (sat && r > mx) begin r = mx; ov = 1'b1; end
    else if (sat && r < mn) begin r = mn; ov = 1'b1; end
    return r[63:0] & msk(w);
  endfunction

  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b, bit sub,
                                          int size, int shape, bit sgn, bit sat, bit q,
                                          output bit anyov);
    int e;
    logic [VW-1:0] res;
    logic [63:0] r;
    bit ov;
    e = 8 << size;
    res = '0;
    anyov = 1'b0;
    if (shape != 0 && size == 3) return '0;
    case (shape)
      0: for (int i = 0; i < (q ? 128 : 64) / e; i++) begin
           r = lane_calc(64'(a >> (i*e)), e, 64'(b >> (i*e)), e, e, sgn, sat, sub, ov);
           res |= VW'(r) << (i*e); anyov |= ov;
         end
      1: for (int i = 0; i < 64 / e; i++) begin
           r = lane_calc(64'(a >> (i*e)), e, 64'(b >> (i*e)), e, 2*e, sgn, sat, sub, ov);
           res |= VW'(r) << (i*2*e); anyov |= ov;
         end
      2: for (int i = 0; i < 64 / e; i++) begin
           r = lane_calc(64'(a >> (i*2*e)), 2*e, 64'(b >> (i*e)), e, 2*e, sgn, sat, sub, ov);
           res |= VW'(r) << (i*2*e); anyov |= ov;
         end
      default: for (int i = 0; i < 64 / e; i++) begin
           r = lane_calc(64'(a >> (i*2*e)), 2*e, 64'(b >> (i*2*e)), 2*e, 2*e, sgn, sat, sub, ov);
           res |= VW'(r >> e) << (i*e); anyov |= ov;
         end
    endcase
    return res;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drives at a negedge, samples at the next negedge
  task automatic apply(bit sub, int size, int shape, bit sgn, bit sat, bit q,
                       logic [VW-1:0] a, logic [VW-1:0] b, bit clr);
    logic [VW-1:0] exp;
    bit ov;
    string req;
    exp = model(a, b, sub, size, shape, sgn, sat, q, ov);
    valid_i = 1'b1; op_i = sub; size_i = 2'(size); shape_i = 2'(shape);
    signed_i = sgn; sat_i = sat; quad_i = q; a_i = a; b_i = b; sat_clr_i = clr;
    @(negedge clk_i);
    exp_sat = (exp_sat & ~clr) | ov;
    case (shape)
      0: req = "R1"; 1: req = "R2"; 2: req = "R3"; default: req = "R4";
    endcase
    if (ov) req = sgn ? "R5" : "R6";
    if (shape != 0 && size == 3) req = "R9";
    chk(res_o === exp, req, "result", res_o, exp);
    chk(valid_o === 1'b1, "R8", "valid_o", VW'(valid_o), VW'(1));
    chk(sat_o === exp_sat, clr ? "R7" : req, "sat_o", VW'(sat_o), VW'(exp_sat));
    last_res = res_o;
  endtask

  task automatic idle(bit clr, logic [VW-1:0] junk);
    valid_i = 1'b0; sat_clr_i = clr; a_i = junk; b_i = ~junk; sat_i = 1'b1;
    @(negedge clk_i);
    exp_sat = exp_sat & ~clr;
    chk(valid_o === 1'b0, "R8", "valid_o idle", VW'(valid_o), VW'(0));
    chk(res_o === last_res, "R8", "res_o hold", res_o, last_res);
    chk(sat_o === exp_sat, "R7", "sat_o idle", VW'(sat_o), VW'(exp_sat));
    sat_clr_i = 1'b0;
  endtask

  function automatic logic [VW-1:0] pick();
    case ($urandom % 6)
      0: return {16{8'h7f}};
      1: return {16{8'h80}};
      2: return '1;
      3: return {8{16'h8000}} | {$urandom, $urandom, $urandom, $urandom} & {8{16'h00ff}};
      default: return {$urandom, $urandom, $urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R10", "valid_o reset", VW'(valid_o), VW'(0));
    chk(res_o === '0, "R10", "res_o reset", res_o, '0);
    chk(sat_o === 1'b0, "R10", "sat_o reset", VW'(sat_o), VW'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    apply(0, 0, 0, 1, 1, 1, {16{8'h7f}}, {16{8'h01}}, 0);   // R5 signed max clamp
    apply(0, 1, 0, 1, 0, 0, {8{16'h7fff}}, {8{16'h0001}}, 0); // R1 wrap, 64-bit
    apply(1, 2, 0, 0, 1, 1, '0, {4{32'h1}}, 0);              // R6 unsigned borrow clamp
    apply(0, 0, 1, 1, 0, 1, {16{8'h80}}, {16{8'h80}}, 1);    // R2 widen, clears R7 flag
    apply(1, 0, 1, 0, 1, 1, '0, {16{8'h01}}, 0);             // R6 widened unsigned borrow
    apply(0, 2, 2, 1, 1, 1, {2{64'h7fffffffffffffff}}, {2{32'h7fffffff}}, 0); // R3 clamp
    apply(0, 1, 3, 0, 0, 1, {4{32'h8000_8000}}, {4{32'h8000_8000}}, 0);       // R4 high half
    apply(0, 0, 3, 1, 1, 1, {8{16'h7f00}}, {8{16'h7f00}}, 1);                 // R7 clr + clamp
    idle(1'b0, '1);                                                           // R8 hold
    apply(0, 3, 1, 1, 1, 1, '1, '1, 1);                                       // R9
    apply(1, 3, 0, 1, 1, 1, {64'h8000000000000000, 64'h1}, {64'h1, 64'h2}, 0); // R5 64-bit
    idle(1'b1, '0);                                                           // R7 clear idle

    for (int n = 0; n < 1500; n++) begin
      if ($urandom % 9 == 0) idle(($urandom % 3) == 0, pick());
      else apply($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
                 $urandom % 2, pick(), pick(), ($urandom % 12) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule